// File: doc/BRIEF.md
# DMA Controller Register and Interrupt Front End

This block is the register side of a multi-channel DMA controller. A bus master uses single-cycle strobes to read and write 32-bit words in a 4 KB window. Through this window it programs each channel's source, destination, link pointer, control and configuration words, and it sets one global configuration word. The block has 8 or 2 channels, chosen by a parameter. It also returns a fixed set of identification bytes.

The transfer engine next to this block reports events through per-channel set pulses, one set for terminal count and one for error. The block latches these into raw interrupt bits. Each channel's configuration word carries the two enable bits that mask these interrupts. A single interrupt line goes high while any enabled raw bit is set. Software acknowledges interrupts by writing ones to one of two clear words.

A read is combinational: `rdata` reflects `addr` in the same cycle. A write takes effect on the rising clock edge where `sel` and `we` are both high. Address bits 1:0 are ignored.

Top module: `dma_regfile`

## Requirements
- R1: `irq` is high exactly when some channel c has raw terminal-count bit c set and its terminal-count enable set, or has raw error bit c set and its error enable set.
- R2: Bit 15 of channel c's configuration word is the terminal-count enable for channel c. Bit 14 of the same word is the error enable.
- R3: Global word offsets are as follows. 0x000 reads the OR of both masked status vectors. 0x004 reads the masked terminal-count vector. 0x00C reads the masked error vector. 0x014 reads the raw terminal-count vector. 0x018 reads the raw error vector. In all of these, bit c belongs to channel c and the upper bits are zero.
- R4: A write to 0x008 clears every raw terminal-count bit that is a 1 in the written data. A write to 0x010 does the same for the raw error bits. Other raw bits are unchanged.
- R5: A set pulse for bit c in the same cycle as a clear of bit c leaves bit c set.
- R6: Reading 0x01C returns a vector in which bit c equals bit 0 of channel c's configuration word.
- R7: Channel c's registers are at 0x100 + 0x20*c + 4*r. For r = 0..4 these are source, destination, link pointer, control and configuration. Each holds 32 bits and reads back what was written. Words r = 5..7 read zero.
- R8: When the channel index (address bits 7:5) is at or above the channel count, a write changes nothing and a read returns zero.
- R9: Offsets 0xFE0 to 0xFFC return one byte per word, zero-extended: 0x80 (0x81 when there are 2 channels), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Word 0x030 is a 32-bit global configuration register that can be read and written. Writes to the status words (0x000, 0x004, 0x00C, 0x014, 0x018, 0x01C) have no effect. All other offsets read zero.
- R11: After reset every register and every raw bit is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access strobe |
| we | input | 1 | Write when high, with `sel` |
| addr | input | 12 | Byte address within the window |
| wdata | input | 32 | Write data |
| tc_set | input | NUM_CH | Terminal-count set pulses, one per channel |
| err_set | input | NUM_CH | Error set pulses, one per channel |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined masked interrupt |

## Verification
Corruption in a raw interrupt bit or a stored enable shows up on `irq` in the same cycle. The next read of the masked or raw status words then shows which bit is wrong. A wrong channel-index decode, such as channel 2 aliasing onto channel 0 in the 2-channel variant, shows up as corrupted data when the aliased channel is read back. The bench therefore runs an 8-channel instance and a 2-channel instance side by side. A behavioural model checks both `rdata` and `irq` on every clock, so a fault becomes visible within one cycle of the access that exposes it.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [11:0]       addr,
  input  logic [31:0]       wdata,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int NREG = 5;
  localparam logic [7:0] ID0 = (NUM_CH == 8) ? 8'h80 : 8'h81;

  logic [31:0] ch_regs [NUM_CH][NREG];
  logic [31:0] gconf;
  logic [NUM_CH-1:0] raw_tc, raw_err, tc_mask, err_mask, en_map;
  logic [NUM_CH-1:0] tc_clr, err_clr;

  logic       is_glob, is_chan, is_id, ch_ok, wr;
  logic [5:0] word;
  logic [2:0] chn, rsel;
  logic [CW-1:0] chi;

  assign is_glob = addr[11:8] == 4'h0;
  assign is_chan = addr[11:8] == 4'h1;
  assign is_id   = addr[11:5] == 7'h7F;
  assign word    = addr[7:2];
  assign chn     = addr[7:5];
  assign rsel    = addr[4:2];
  assign chi     = chn[CW-1:0];
  assign ch_ok   = {29'd0, chn} < NUM_CH;
  assign wr      = sel & we;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign tc_mask[c]  = ch_regs[c][4][15];
    assign err_mask[c] = ch_regs[c][4][14];
    assign en_map[c]   = ch_regs[c][4][0];
  end

  assign tc_clr  = (wr && is_glob && word == 6'd2) ? wdata[NUM_CH-1:0] : '0;
  assign err_clr = (wr && is_glob && word == 6'd4) ? wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++)
        for (int r = 0; r < NREG; r++) ch_regs[c][r] <= '0;
      gconf   <= '0;
      raw_tc  <= '0;
      raw_err <= '0;
    end else begin
      if (wr && is_chan && ch_ok && rsel < 3'd5) ch_regs[chi][rsel] <= wdata;
      if (wr && is_glob && word == 6'd12) gconf <= wdata;
      raw_tc  <= (raw_tc & ~tc_clr) | tc_set;
      raw_err <= (raw_err & ~err_clr) | err_set;
    end
  end

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = ID0;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h0A;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] zx(input logic [NUM_CH-1:0] v);
    zx = '0;
    zx[NUM_CH-1:0] = v;
  endfunction

  always_comb begin
    rdata = '0;
    if (is_id) begin
      rdata = {24'd0, id_byte(rsel)};
    end else if (is_chan) begin
      if (ch_ok && rsel < 3'd5) rdata = ch_regs[chi][rsel];
    end else if (is_glob) begin
      case (word)
        6'd0:  rdata = zx((raw_tc & tc_mask) | (raw_err & err_mask));
        6'd1:  rdata = zx(raw_tc & tc_mask);
        6'd3:  rdata = zx(raw_err & err_mask);
        6'd5:  rdata = zx(raw_tc);
        6'd6:  rdata = zx(raw_err);
        6'd7:  rdata = zx(en_map);
        6'd12: rdata = gconf;
        default: rdata = '0;
      endcase
    end
  end

  assign irq = |(raw_tc & tc_mask) | |(raw_err & err_mask);
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              we,
  input logic [11:0]       addr,
  input logic [31:0]       wdata,
  input logic [NUM_CH-1:0] tc_set,
  input logic [NUM_CH-1:0] err_set,
  input logic [NUM_CH-1:0] raw_tc,
  input logic [NUM_CH-1:0] raw_err,
  input logic [31:0]       rdata,
  input logic              irq
);
  logic tc_clr_wr, err_clr_wr;
  assign tc_clr_wr  = sel && we && addr[11:2] == 10'h002;
  assign err_clr_wr = sel && we && addr[11:2] == 10'h004;

  p_irq_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_tc == '0 && raw_err == '0) |-> !irq);

  p_tc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tc_clr_wr |=> ((raw_tc & $past(wdata[NUM_CH-1:0]) & ~$past(tc_set)) == '0));

  p_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_wr |=> ((raw_err & $past(wdata[NUM_CH-1:0]) & ~$past(err_set)) == '0));

  p_tc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_clr_wr && tc_set == '0) |=> $stable(raw_tc));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != '0) |=> ((raw_tc & $past(tc_set)) == $past(tc_set)));

  p_err_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != '0) |=> ((raw_err & $past(err_set)) == $past(err_set)));

  p_id_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[11:2] == 10'h3FF) |-> rdata == 32'h0000_00B1);

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[11:2] == 10'h00D) |-> rdata == '0);
endmodule

bind dma_regfile dma_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_dma_regfile.sv
`timescale 1ns/1ps
module test_dma_regfile;
  logic clk = 0, rst_n = 0, sel = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0] tcs = '0, errs = '0;
  logic [31:0] rd8, rd2;
  logic irq8, irq2;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_regfile #(.NUM_CH(8)) i_dma_regfile (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .tc_set(tcs), .err_set(errs), .rdata(rd8), .irq(irq8));
  dma_regfile #(.NUM_CH(2)) i_dma_regfile_2 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .tc_set(tcs[1:0]), .err_set(errs[1:0]), .rdata(rd2), .irq(irq2));

  logic [31:0] m_reg [2][8][5];
  logic [31:0] m_gconf [2];
  logic [7:0]  m_tc [2], m_err [2];

  function automatic int nch(int k); return k ? 2 : 8; endfunction

  function automatic logic [7:0] mmask(int k, int bitn);
    logic [7:0] m = '0;
    for (int c = 0; c < nch(k); c++) m[c] = m_reg[k][c][4][bitn];
    return m;
  endfunction

  function automatic logic [31:0] exp_rd(int k, logic [11:0] a);
    int w = a[7:2], ch = a[7:5], r = a[4:2];
    logic [7:0] idb [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (a >= 12'hFE0) return (r == 0 && k == 1) ? 32'h81 : {24'd0, idb[r]};
    if (a >= 12'h100 && a < 12'h200) return (ch < nch(k) && r < 5) ? m_reg[k][ch][r] : 32'd0;
    if (a >= 12'h100) return 0;
    case (w)
      0: return {24'd0, (m_tc[k] & mmask(k, 15)) | (m_err[k] & mmask(k, 14))};
      1: return {24'd0, m_tc[k] & mmask(k, 15)};
      3: return {24'd0, m_err[k] & mmask(k, 14)};
      5: return {24'd0, m_tc[k]};
      6: return {24'd0, m_err[k]};
      7: return {24'd0, mmask(k, 0)};
      12: return m_gconf[k];
      default: return 0;
    endcase
  endfunction

  function automatic logic exp_irq(int k);
    return ((m_tc[k] & mmask(k, 15)) | (m_err[k] & mmask(k, 14))) != 0;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 8; c++) for (int r = 0; r < 5; r++) m_reg[k][c][r] = 0;
      m_gconf[k] = 0; m_tc[k] = 0; m_err[k] = 0;
    end
  endtask

  task automatic check(string tag);
    for (int k = 0; k < 2; k++) begin
      logic [31:0] ar = k ? rd2 : rd8;
      logic ai = k ? irq2 : irq8;
      vectors++;
      if (ar !== exp_rd(k, addr) || ai !== exp_irq(k)) begin
        fails++;
        $display("FAIL %s inst%0d addr=%h rdata=%h irq=%b expected rdata=%h irq=%b",
                 tag, k, addr, ar, ai, exp_rd(k, addr), exp_irq(k));
      end
    end
  endtask

  task automatic cyc(string tag, logic s, logic w, logic [11:0] a, logic [31:0] d,
                     logic [7:0] t = 0, logic [7:0] e = 0);
    sel = s; we = w; addr = a; wdata = d; tcs = t; errs = e;
    #1 check(tag);
    for (int k = 0; k < 2; k++) begin
      logic [7:0] lim = (k ? 8'h03 : 8'hFF);
      int ch = a[7:5], r = a[4:2];
      if (s && w) begin
        if (a >= 12'h100 && a < 12'h200 && ch < nch(k) && r < 5) m_reg[k][ch][r] = d;
        if (a[11:2] == 10'd12) m_gconf[k] = d;
        if (a[11:2] == 10'd2) m_tc[k] &= ~d[7:0];
        if (a[11:2] == 10'd4) m_err[k] &= ~d[7:0];
      end
      m_tc[k]  = (m_tc[k]  | t) & lim;
      m_err[k] = (m_err[k] | e) & lim;
    end
    @(negedge clk);
  endtask

  task automatic rd(string tag, logic [11:0] a); cyc(tag, 1, 0, a, 0); endtask
  task automatic wrw(string tag, logic [11:0] a, logic [31:0] d); cyc(tag, 1, 1, a, d); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R11 reset state
    rd("R11", 12'h000); rd("R11", 12'h014); rd("R11", 12'h130);
    rst_n = 1;
    @(negedge clk);
    rd("R11", 12'h01C);
    // R7 channel registers
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 5; r++)
        wrw("R7", 12'h100 + 12'(c * 32 + r * 4), 32'hA5000000 + 32'(c * 16 + r) * 32'h01010101);
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 8; r++) rd("R7", 12'h100 + 12'(c * 32 + r * 4));
    // R8 out-of-range index must not alias onto channel 0
    wrw("R8", 12'h100, 32'h1111_0000);
    wrw("R8", 12'h140, 32'h2222_0000);
    rd("R8", 12'h100); rd("R8", 12'h140); rd("R8", 12'h1F0);
    // R2 R6 enables: ch0 tc+en, ch1 err, ch3 both
    wrw("R2", 12'h110, 32'h0000_8001);
    wrw("R2", 12'h130, 32'h0000_4000);
    wrw("R2", 12'h170, 32'h0000_C001);
    wrw("R6", 12'h190, 32'h0000_0001);
    rd("R6", 12'h01C);
    // R1 R3 interrupts
    cyc("R1", 0, 0, 12'h000, 0, 8'h06, 8'h00);
    rd("R1", 12'h000); rd("R3", 12'h004); rd("R3", 12'h014);
    cyc("R1", 0, 0, 12'h000, 0, 8'h00, 8'h0B);
    rd("R3", 12'h00C); rd("R3", 12'h018); rd("R3", 12'h000);
    cyc("R1", 0, 0, 12'h000, 0, 8'h09, 8'h00);
    rd("R1", 12'h004);
    // R4 clear by ones
    wrw("R4", 12'h008, 32'h0000_0001);
    rd("R4", 12'h014); rd("R4", 12'h000);
    wrw("R4", 12'h010, 32'h0000_00FF);
    rd("R4", 12'h018);
    wrw("R4", 12'h008, 32'hFFFF_FFFF);
    rd("R4", 12'h014);
    // R5 set beats clear
    cyc("R5", 1, 1, 12'h008, 32'hFF, 8'h03, 8'h00);
    rd("R5", 12'h014);
    cyc("R5", 1, 1, 12'h010, 32'h02, 8'h00, 8'h02);
    rd("R5", 12'h018);
    // R10 read-only and global config
    wrw("R10", 12'h014, 32'h0);
    wrw("R10", 12'h018, 32'h0);
    wrw("R10", 12'h01C, 32'hFF);
    wrw("R10", 12'h000, 32'hFF);
    rd("R10", 12'h014); rd("R10", 12'h018); rd("R10", 12'h01C);
    wrw("R10", 12'h030, 32'hDEAD_BEEF);
    rd("R10", 12'h030);
    rd("R10", 12'h034); rd("R10", 12'h200); rd("R10", 12'h800); rd("R10", 12'h020);
    // R9 identification
    for (int i = 0; i < 8; i++) rd("R9", 12'hFE0 + 12'(i * 4));
    // R1 mask removal drops irq
    wrw("R1", 12'h110, 32'h0);
    wrw("R1", 12'h130, 32'h0);
    wrw("R1", 12'h170, 32'h0);
    rd("R1", 12'h000);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule